// File: doc/BRIEF.md
# Serial Switch Monitor with Maskable Interrupt

This block watches a word of switch inputs and reports their levels to a controller over a four-wire serial slave port. The port has a chip select, a serial clock, data in and data out. A falling chip select freezes the current input levels into a shift register and clears any pending interrupt. The controller then clocks the word out, most significant bit first, while it clocks a new interrupt mask in. When chip select rises, the shifted-in word becomes the mask. Whenever an input whose mask bit is 1 differs from the levels frozen at the last chip-select fall, the block pulls its interrupt line low. The line is an open-drain output, so it is modelled as a pull-low enable.

All port pins are oversampled by the block clock through two-flop synchronisers, and the switch inputs pass through a synchroniser of their own. The serial clock idles high. Data in is sampled on falling serial-clock edges, and the shift register advances on rising edges. Without limit on the clock count, data in reappears on data out sixteen clocks later, so several devices can be chained. A monitor-enable input, synchronous to the block clock, turns off both input monitoring and the interrupt. Data in is a plain input: an undriven pin must be tied to 0 outside the block.

Top module: `sms_switch_monitor`

## Requirements
- R1: After reset the interrupt is released, data out is not enabled and the mask is all ones. The comparison reference settles to the synchronised inputs, so steady inputs raise no interrupt, but a later change on any input does.
- R2: A chip-select fall loads the effective input word into the shift register. Bit 15 appears on data out first, and the whole word is read most significant bit first.
- R3: A chip-select fall clears a pending interrupt and makes the captured word the new comparison reference.
- R4: The serial clock idles high. Each falling edge with chip select low samples data in, and each rising edge shifts that bit into bit 0 and presents the next bit on data out.
- R5: A chip-select rise copies the shift register into the mask. An input whose mask bit is 1 can raise the interrupt, and one whose mask bit is 0 cannot.
- R6: The interrupt pull-low enable asserts when an unmasked input differs from the reference. It stays asserted, even after the input returns, until the next chip-select fall. No port ever drives the interrupt high.
- R7: While monitor enable is 0, the inputs read as all zeros and the interrupt is released and cleared. After re-enabling, inputs that differ from the stored reference raise the interrupt.
- R8: With more than 16 clocks in one select period, data out repeats data in delayed by 16 clocks. Only the last 16 bits shifted in become the mask.
- R9: The data-out enable is 0 while chip select is high and 1 while it is low.
- R10: An input change that reaches the comparator in the same cycle as a chip-select fall is captured into the snapshot and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial port |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_in | input | 16 | Switch input levels, asynchronous |
| mon_en | input | 1 | 1 enables input monitoring and the interrupt |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_sdi | input | 1 | Serial data in, tie to 0 when undriven |
| spi_sdo | output | 1 | Serial data out value |
| spi_sdo_oe | output | 1 | Serial data out enable, 0 means high impedance |
| irq_pull_low | output | 1 | 1 pulls the open-drain interrupt line low |

## Verification
The interrupt clear and the change detector can act in the same cycle. This happens when a switch edge and a chip-select fall leave their synchronisers on the same clock edge. The bench provokes it by changing the inputs and lowering chip select on the same clock. The result is right when the read-out word already holds the new levels and the interrupt stays released after the transfer. A second overlap, a mask commit while an unmasked change is pending, is covered by writing a narrow mask and then toggling a masked bit and an unmasked bit in turn.

// File: rtl/sms_pkg.sv
// Package: shared sizing for the serial switch monitor.
// Assumes: every module of the block takes its defaults from here.
package sms_pkg;
    parameter int unsigned SMS_NUM_IN      = 16;
    parameter int unsigned SMS_SYNC_STAGES = 2;
    localparam int unsigned SMS_PORT_PINS  = 3;
endpackage

// File: rtl/sms_sync.sv
// Module: sms_sync
// Multi-stage flop synchroniser for a bus of independent single-bit signals.
// Assumes: each bit is quasi-static or handled bitwise; no bus coherency is implied.
module sms_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage captures the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q[0] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
        end
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            // Each further stage resolves metastability of the one before.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[g] <= RST_VAL;
                end else begin
                    stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sms_spi_port.sv
// Module: sms_spi_port
// Serial slave datapath: edge detection on the synchronised pins, the
// snapshot/shift register and the interrupt mask register.
// Assumes: pins are already synchronised to clk; the serial clock idles high
// and each of its phases lasts at least a few block clocks.
module sms_spi_port #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_s,
    input  logic             sclk_s,
    input  logic             sdi_s,
    input  logic [WIDTH-1:0] load_word,
    output logic             cs_fall,
    output logic             cs_rise,
    output logic [WIDTH-1:0] mask_q,
    output logic             sdo,
    output logic             sdo_oe
);
    localparam logic [WIDTH-1:0] MASK_RST = '1;

    logic             cs_prev_q;
    logic             sclk_prev_q;
    logic             in_bit_q;
    logic [WIDTH-1:0] shift_q;
    logic             sclk_rise;
    logic             sclk_fall;

    // Remember last pin levels so that edges can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev_q   <= 1'b1;
            sclk_prev_q <= 1'b1;
        end else begin
            cs_prev_q   <= cs_s;
            sclk_prev_q <= sclk_s;
        end
    end

    // Edge strobes; serial clock edges count only inside a select period.
    always_comb begin
        cs_fall   = cs_prev_q & ~cs_s;
        cs_rise   = ~cs_prev_q & cs_s;
        sclk_rise = ~cs_s & ~cs_prev_q & sclk_s & ~sclk_prev_q;
        sclk_fall = ~cs_s & ~cs_prev_q & ~sclk_s & sclk_prev_q;
    end

    // Hold the data-in bit taken at the latest falling serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_bit_q <= 1'b0;
        end else if (cs_fall) begin
            in_bit_q <= 1'b0;
        end else if (sclk_fall) begin
            in_bit_q <= sdi_s;
        end
    end

    // Snapshot on select fall, shift towards the MSB on rising serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (cs_fall) begin
            shift_q <= load_word;
        end else if (sclk_rise) begin
            shift_q <= {shift_q[WIDTH-2:0], in_bit_q};
        end
    end

    // Commit the shifted-in word as the mask when select rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= MASK_RST;
        end else if (cs_rise) begin
            mask_q <= shift_q;
        end
    end

    assign sdo    = shift_q[WIDTH-1];
    assign sdo_oe = ~cs_s;
endmodule

// File: rtl/sms_change_irq.sv
// Module: sms_change_irq
// Reference snapshot, masked change detection and the sticky interrupt.
// Assumes: sw_eff is synchronous to clk; cs_fall is a one-cycle strobe.
module sms_change_irq #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned SETTLE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mon_en,
    input  logic [WIDTH-1:0] sw_eff,
    input  logic [WIDTH-1:0] mask,
    input  logic             cs_fall,
    output logic             irq_pull
);
    localparam int unsigned CNT_W = $clog2(SETTLE + 1);
    localparam logic [CNT_W-1:0] SETTLE_END = CNT_W'(SETTLE);

    logic [CNT_W-1:0] settle_q;
    logic             settled;
    logic [WIDTH-1:0] ref_q;
    logic             pend_q;
    logic             hit;

    // Count the cycles the synchronisers need to fill after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_q <= '0;
        end else if (!settled) begin
            settle_q <= settle_q + 1'b1;
        end
    end

    assign settled = (settle_q == SETTLE_END);

    // Any unmasked difference from the reference counts as a change.
    assign hit = |((sw_eff ^ ref_q) & mask);

    // Reference follows inputs while settling, then reloads at each select fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else if (!settled || cs_fall) begin
            ref_q <= sw_eff;
        end
    end

    // Sticky pending flag; clear takes priority over a new change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (!settled || !mon_en || cs_fall) begin
            pend_q <= 1'b0;
        end else if (hit) begin
            pend_q <= 1'b1;
        end
    end

    assign irq_pull = pend_q & mon_en;
endmodule

// File: rtl/sms_switch_monitor.sv
// Module: sms_switch_monitor (top)
// Serial switch monitor: synchronises switches and port pins, reads the inputs
// out through the serial port, takes a new mask in, and drives a maskable
// open-drain interrupt as a pull-low enable.
// Assumes: mon_en is synchronous to clk; sw_in and the port pins are not.
module sms_switch_monitor #(
    parameter int unsigned N_IN        = sms_pkg::SMS_NUM_IN,
    parameter int unsigned SYNC_STAGES = sms_pkg::SMS_SYNC_STAGES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] sw_in,
    input  logic            mon_en,
    input  logic            spi_cs_n,
    input  logic            spi_sclk,
    input  logic            spi_sdi,
    output logic            spi_sdo,
    output logic            spi_sdo_oe,
    output logic            irq_pull_low
);
    localparam int unsigned PINS   = sms_pkg::SMS_PORT_PINS;
    localparam int unsigned SETTLE = SYNC_STAGES + 1;
    localparam logic [PINS-1:0] PIN_IDLE = 3'b110;

    logic [N_IN-1:0] sw_s;
    logic [N_IN-1:0] sw_eff;
    logic [PINS-1:0] pins_s;
    logic            cs_fall;
    logic            cs_rise;
    logic [N_IN-1:0] mask_q;

    sms_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sw_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sw_in),
        .q     (sw_s)
    );

    sms_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_cs_n, spi_sclk, spi_sdi}),
        .q     (pins_s)
    );

    // Monitoring off makes every input read as 0.
    assign sw_eff = mon_en ? sw_s : '0;

    sms_spi_port #(.WIDTH(N_IN)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (pins_s[2]),
        .sclk_s    (pins_s[1]),
        .sdi_s     (pins_s[0]),
        .load_word (sw_eff),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .mask_q    (mask_q),
        .sdo       (spi_sdo),
        .sdo_oe    (spi_sdo_oe)
    );

    sms_change_irq #(.WIDTH(N_IN), .SETTLE(SETTLE)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mon_en   (mon_en),
        .sw_eff   (sw_eff),
        .mask     (mask_q),
        .cs_fall  (cs_fall),
        .irq_pull (irq_pull_low)
    );
endmodule

// File: rtl/sms_switch_monitor_chk.sv
// Module: sms_switch_monitor_chk
// Property checker for the serial switch monitor, bound to the top module.
// Assumes: connected to top-level ports plus the select-fall strobe and the
// effective input word.
module sms_switch_monitor_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mon_en,
    input logic             spi_cs_n,
    input logic             spi_sdo,
    input logic             spi_sdo_oe,
    input logic             irq_pull_low,
    input logic             cs_fall,
    input logic [WIDTH-1:0] sw_eff
);
    // R2: the first bit out after a select fall is the snapshot MSB.
    a_r2_snapshot_msb: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (spi_sdo == $past(sw_eff[WIDTH-1])));

    // R3: a select fall leaves the interrupt released on the next cycle.
    a_r3_clear_on_select: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> !irq_pull_low);

    // R6: an asserted interrupt holds until a select fall or disable.
    a_r6_sticky_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pull_low && !cs_fall) |=> (irq_pull_low || !mon_en));

    // R7: monitoring off clears the interrupt.
    a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> !irq_pull_low);

    // R9: data out is released after select has been high long enough.
    a_r9_sdo_released: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |-> !spi_sdo_oe);
endmodule

bind sms_switch_monitor sms_switch_monitor_chk #(.WIDTH(N_IN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mon_en       (mon_en),
    .spi_cs_n     (spi_cs_n),
    .spi_sdo      (spi_sdo),
    .spi_sdo_oe   (spi_sdo_oe),
    .irq_pull_low (irq_pull_low),
    .cs_fall      (cs_fall),
    .sw_eff       (sw_eff)
);

// File: tb/tb_sms_switch_monitor.sv
// Scoreboard bench: the transfer task queues the expected read-out word and a
// monitor process collects data out and compares it.
module tb_sms_switch_monitor;
    localparam int HALF = 6;

    typedef struct {
        logic [31:0] exp;
        int          nbits;
        string       tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sw_in = 16'hA5C3;
    logic        mon_en = 1'b1;
    logic        spi_cs_n = 1'b1;
    logic        spi_sclk = 1'b1;
    logic        spi_sdi = 1'b0;
    logic        spi_sdo;
    logic        spi_sdo_oe;
    logic        irq_pull_low;

    int n_checks = 0;
    int n_fail = 0;
    sb_item_t sb_q[$];

    always #5 clk = ~clk;

    sms_switch_monitor dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_in        (sw_in),
        .mon_en       (mon_en),
        .spi_cs_n     (spi_cs_n),
        .spi_sclk     (spi_sclk),
        .spi_sdi      (spi_sdi),
        .spi_sdo      (spi_sdo),
        .spi_sdo_oe   (spi_sdo_oe),
        .irq_pull_low (irq_pull_low)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: one select period of nbits serial clocks, optional input change
    // on the same clock as the select fall.
    task automatic xfer(input logic [31:0] tx, input int nbits, input logic [31:0] exp,
                        input string tag, input bit chg, input logic [15:0] chg_val);
        sb_item_t it;
        it.exp = exp;
        it.nbits = nbits;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        spi_cs_n = 1'b0;
        if (chg) sw_in = chg_val;
        wait_clk(HALF);
        for (int i = nbits - 1; i >= 0; i--) begin
            spi_sdi = tx[i];
            wait_clk(HALF);
            spi_sclk = 1'b0;
            wait_clk(HALF);
            spi_sclk = 1'b1;
        end
        wait_clk(HALF);
        spi_cs_n = 1'b1;
        spi_sdi = 1'b0;
        wait_clk(HALF);
    endtask

    // Monitor: collect data out at each falling serial clock and compare.
    initial begin
        forever begin
            sb_item_t it;
            logic [31:0] word;
            bit oe_ok;
            @(negedge spi_cs_n);
            if (sb_q.size() == 0) begin
                chk(1'b0, "scoreboard", 32'h0, 32'h1);
            end else begin
                it = sb_q.pop_front();
                word = '0;
                oe_ok = 1'b1;
                for (int b = 0; b < it.nbits; b++) begin
                    @(negedge spi_sclk);
                    #1;
                    word = {word[30:0], spi_sdo};
                    if (spi_sdo_oe !== 1'b1) oe_ok = 1'b0;
                end
                chk(word === it.exp, it.tag, word, it.exp);
                chk(oe_ok, "R9 data out enabled in select", {31'b0, oe_ok}, 32'h1);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(10);
        // R1: reset state, steady inputs raise nothing.
        chk(irq_pull_low == 1'b0, "R1 irq released after reset", {31'b0, irq_pull_low}, 32'h0);
        chk(spi_sdo_oe == 1'b0, "R1 R9 data out off", {31'b0, spi_sdo_oe}, 32'h0);
        // R1 R6: default mask lets bit 0 raise the interrupt.
        sw_in = 16'hA5C2;
        wait_clk(8);
        chk(irq_pull_low == 1'b1, "R1 R6 change raises irq", {31'b0, irq_pull_low}, 32'h1);
        sw_in = 16'hA5C3;
        wait_clk(8);
        chk(irq_pull_low == 1'b1, "R6 irq sticky after return", {31'b0, irq_pull_low}, 32'h1);
        // R2 R3: read snapshot, which clears the interrupt.
        xfer(32'h0000FFFF, 16, 32'h0000A5C3, "R2 snapshot read", 1'b0, 16'h0);
        chk(irq_pull_low == 1'b0, "R3 cleared by select fall", {31'b0, irq_pull_low}, 32'h0);
        // R5: narrow mask 0x00F0.
        xfer(32'h000000F0, 16, 32'h0000A5C3, "R2 second read", 1'b0, 16'h0);
        sw_in = 16'hA4C3;
        wait_clk(8);
        chk(irq_pull_low == 1'b0, "R5 masked bit quiet", {31'b0, irq_pull_low}, 32'h0);
        sw_in = 16'hA4D3;
        wait_clk(8);
        chk(irq_pull_low == 1'b1, "R5 unmasked bit raises", {31'b0, irq_pull_low}, 32'h1);
        xfer(32'h0000FFFF, 16, 32'h0000A4D3, "R2 read after change", 1'b0, 16'h0);
        chk(irq_pull_low == 1'b0, "R3 cleared again", {31'b0, irq_pull_low}, 32'h0);
        // R10: input change on the same clock as select fall.
        xfer(32'h0000FFFF, 16, 32'h00001234, "R10 same-cycle snapshot", 1'b1, 16'h1234);
        wait_clk(8);
        chk(irq_pull_low == 1'b0, "R10 no irq from captured change", {31'b0, irq_pull_low}, 32'h0);
        // R7: monitoring off.
        mon_en = 1'b0;
        sw_in = 16'h0F0F;
        wait_clk(8);
        chk(irq_pull_low == 1'b0, "R7 irq off when disabled", {31'b0, irq_pull_low}, 32'h0);
        xfer(32'h0000FFFF, 16, 32'h00000000, "R7 inputs read zero", 1'b0, 16'h0);
        mon_en = 1'b1;
        wait_clk(8);
        chk(irq_pull_low == 1'b1, "R7 re-enable compares to zero reference", {31'b0, irq_pull_low}, 32'h1);
        xfer(32'h0000FFFF, 16, 32'h00000F0F, "R2 read after enable", 1'b0, 16'h0);
        // R4 R8: 32-clock chain, pass-through then mask 0x0001.
        xfer(32'hBEEF0001, 32, 32'h0F0FBEEF, "R4 R8 chain pass-through", 1'b0, 16'h0);
        sw_in = 16'h0F0D;
        wait_clk(8);
        chk(irq_pull_low == 1'b0, "R8 mask from last 16 bits: bit1 off", {31'b0, irq_pull_low}, 32'h0);
        sw_in = 16'h0F0C;
        wait_clk(8);
        chk(irq_pull_low == 1'b1, "R8 mask from last 16 bits: bit0 on", {31'b0, irq_pull_low}, 32'h1);
        xfer(32'h0000FFFF, 16, 32'h00000F0C, "R2 final read", 1'b0, 16'h0);
        chk(irq_pull_low == 1'b0, "R3 final clear", {31'b0, irq_pull_low}, 32'h0);
        chk(spi_sdo_oe == 1'b0, "R9 released after select", {31'b0, spi_sdo_oe}, 32'h0);
        wait_clk(4);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule